// File: doc/BRIEF.md
# E1 Loopback and Test-Mode Path Selector

This block is the digital routing fabric of a single E1 transceiver. It sits between four dual-rail mark sources and sinks: the transmit data arriving from the terminal side, the data headed for the line driver, the marks recovered by the receive slicer, and the receive data handed back to the terminal. Every signal travels as a positive-mark rail paired with a negative-mark rail, `LANES` bits wide each.

Two static control levels pick one of four routes. With both low, the transmit and receive paths are independent. With only the local request high, transmit data still goes to the line and is also turned back into the receive outputs, while the slicer marks are discarded. With only the remote request high, recovered marks replace the terminal's transmit data on the line and are still delivered to the receive outputs, while the terminal's transmit data is discarded. With both high, all data outputs are driven to zero and the shared output-enable drops, so pads can be held in high impedance for board test.

The control levels pass through a synchronizer and a single mode register. A change on the controls therefore moves every route and the enable on one common clock edge. All outputs are registered.

Top module: `e1_path_router`

## Requirements
- R1: While `rst` is high and on the first edges after it falls, all data outputs are 0, `out_en` is 1, and the routing mode is the independent (normal) mode.
- R2: In normal mode (local request 0, remote request 0), one clock after sampling, `line_p/line_n` equal `tx_p/tx_n` and `rxo_p/rxo_n` equal `slc_p/slc_n`; `out_en` is 1.
- R3: In local-loop mode (local request 1, remote request 0), `line_p/line_n` and `rxo_p/rxo_n` both equal `tx_p/tx_n` one clock after sampling; the slicer inputs have no effect on any output.
- R4: In remote-loop mode (local request 0, remote request 1), `line_p/line_n` and `rxo_p/rxo_n` both equal `slc_p/slc_n` one clock after sampling; the transmit inputs have no effect on any output.
- R5: In test mode (both requests 1), `out_en` is 0 and every data output bit is 0.
- R6: A new control level that is present at `SYNC_STAGES+2` consecutive rising edges governs the outputs registered at the last of them; all outputs and the enable switch to the new mode on the same edge, and a control pulse is carried through the same delay unchanged.
- R7: The positive and negative rails are switched together: a positive output bit is only ever taken from a positive input bit, and a negative output bit only from a negative input bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_lb_req | input | 1 | Local loopback request level |
| rem_lb_req | input | 1 | Remote loopback request level |
| tx_p | input | LANES | Terminal transmit positive marks |
| tx_n | input | LANES | Terminal transmit negative marks |
| slc_p | input | LANES | Slicer recovered positive marks |
| slc_n | input | LANES | Slicer recovered negative marks |
| line_p | output | LANES | Positive marks to the line driver |
| line_n | output | LANES | Negative marks to the line driver |
| rxo_p | output | LANES | Receive positive marks to the terminal |
| rxo_n | output | LANES | Receive negative marks to the terminal |
| out_en | output | 1 | Output enable for all external outputs (0 in test mode) |

## Verification
Data results are due one rising edge after the inputs are sampled, while a change of the control levels reaches the outputs only at the `SYNC_STAGES+2`-th edge at which it is present. The bench keeps a queue of past control levels exactly that long and picks the mode from its oldest entry, computing the expected routes from the data present at the same edge. Inputs change on the falling edge and all outputs are compared on the following falling edge, so each comparison sees values registered by exactly one rising edge. Single-cycle control pulses and random data on the ignored inputs in each loopback mode exercise the delay and the discard rules.

// File: rtl/e1lb_pkg.sv
package e1lb_pkg;

  // One-hot route selection held in the mode register.
  typedef enum logic [3:0] {
    RT_INDEP  = 4'b0001,
    RT_LOCAL  = 4'b0010,
    RT_REMOTE = 4'b0100,
    RT_TEST   = 4'b1000
  } route_t;

  function automatic route_t decode_route(input logic loc_req, input logic rem_req);
    route_t r;
    case ({loc_req, rem_req})
      2'b00:   r = RT_INDEP;
      2'b10:   r = RT_LOCAL;
      2'b01:   r = RT_REMOTE;
      default: r = RT_TEST;
    endcase
    return r;
  endfunction

  // Which destination a selector feeds.
  localparam int SIDE_LINE = 0;
  localparam int SIDE_RECV = 1;

endpackage

// File: rtl/e1lb_mode_sync.sv
module e1lb_mode_sync
  import e1lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   loc_req,
  input  logic   rem_req,
  output route_t route_q
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] stage_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 2'b00;
          else     stage_q[0] <= {loc_req, rem_req};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= 2'b00;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  // Single register: both control bits land together, so no partial route.
  always_ff @(posedge clk) begin
    if (rst) route_q <= RT_INDEP;
    else     route_q <= decode_route(stage_q[LAST][1], stage_q[LAST][0]);
  end

  p_one_route_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(route_q) == 1);

  p_route_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> route_q == RT_INDEP);

endmodule

// File: rtl/e1lb_rail_sel.sv
module e1lb_rail_sel
  import e1lb_pkg::*;
#(
  parameter int LANES = 1,
  parameter int SIDE  = SIDE_LINE
) (
  input  route_t             route,
  input  logic [LANES-1:0]   tx_p,
  input  logic [LANES-1:0]   tx_n,
  input  logic [LANES-1:0]   slc_p,
  input  logic [LANES-1:0]   slc_n,
  output logic [LANES-1:0]   y_p,
  output logic [LANES-1:0]   y_n
);

  logic use_tx;
  logic blank;

  assign blank = (route == RT_TEST);

  generate
    if (SIDE == SIDE_LINE) begin : g_line
      // Line driver takes terminal data except when the far end is echoed.
      assign use_tx = (route != RT_REMOTE);
    end else begin : g_recv
      // Receive side takes slicer data except when transmit is turned back.
      assign use_tx = (route == RT_LOCAL);
    end
  endgenerate

  // One select per pair: both rails of a lane always follow the same source.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [1:0] pair;
      always_comb begin
        if (blank)       pair = 2'b00;
        else if (use_tx) pair = {tx_p[i], tx_n[i]};
        else             pair = {slc_p[i], slc_n[i]};
      end
      assign y_p[i] = pair[1];
      assign y_n[i] = pair[0];
    end
  endgenerate

endmodule

// File: rtl/e1_path_router.sv
module e1_path_router
  import e1lb_pkg::*;
#(
  parameter int LANES       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loc_lb_req,
  input  logic             rem_lb_req,
  input  logic [LANES-1:0] tx_p,
  input  logic [LANES-1:0] tx_n,
  input  logic [LANES-1:0] slc_p,
  input  logic [LANES-1:0] slc_n,
  output logic [LANES-1:0] line_p,
  output logic [LANES-1:0] line_n,
  output logic [LANES-1:0] rxo_p,
  output logic [LANES-1:0] rxo_n,
  output logic             out_en
);

  route_t           route_q;
  logic [LANES-1:0] line_p_d, line_n_d, rxo_p_d, rxo_n_d;

  e1lb_mode_sync #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .clk     (clk),
    .rst     (rst),
    .loc_req (loc_lb_req),
    .rem_req (rem_lb_req),
    .route_q (route_q)
  );

  e1lb_rail_sel #(.LANES(LANES), .SIDE(SIDE_LINE)) u_line_sel (
    .route (route_q),
    .tx_p  (tx_p),
    .tx_n  (tx_n),
    .slc_p (slc_p),
    .slc_n (slc_n),
    .y_p   (line_p_d),
    .y_n   (line_n_d)
  );

  e1lb_rail_sel #(.LANES(LANES), .SIDE(SIDE_RECV)) u_recv_sel (
    .route (route_q),
    .tx_p  (tx_p),
    .tx_n  (tx_n),
    .slc_p (slc_p),
    .slc_n (slc_n),
    .y_p   (rxo_p_d),
    .y_n   (rxo_n_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      line_p <= '0;
      line_n <= '0;
      rxo_p  <= '0;
      rxo_n  <= '0;
      out_en <= 1'b1;
    end else begin
      line_p <= line_p_d;
      line_n <= line_n_d;
      rxo_p  <= rxo_p_d;
      rxo_n  <= rxo_n_d;
      out_en <= (route_q != RT_TEST);
    end
  end

  p_indep_r2: assert property (@(posedge clk) disable iff (rst)
    route_q == RT_INDEP |=> (line_p == $past(tx_p) && line_n == $past(tx_n) &&
                             rxo_p == $past(slc_p) && rxo_n == $past(slc_n) && out_en));

  p_local_r3: assert property (@(posedge clk) disable iff (rst)
    route_q == RT_LOCAL |=> (line_p == $past(tx_p) && line_n == $past(tx_n) &&
                             rxo_p == $past(tx_p) && rxo_n == $past(tx_n) && out_en));

  p_remote_r4: assert property (@(posedge clk) disable iff (rst)
    route_q == RT_REMOTE |=> (line_p == $past(slc_p) && line_n == $past(slc_n) &&
                              rxo_p == $past(slc_p) && rxo_n == $past(slc_n) && out_en));

  p_test_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    route_q == RT_TEST |=> (!out_en && line_p == '0 && line_n == '0 &&
                            rxo_p == '0 && rxo_n == '0));

  p_no_rail_cross_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (((line_p | rxo_p) & ~$past(tx_p | slc_p)) == '0 &&
              ((line_n | rxo_n) & ~$past(tx_n | slc_n)) == '0));

endmodule

// File: tb/e1_path_router_test.sv
module e1_path_router_test;

  localparam int LANES = 2;
  localparam int SYNC  = 2;
  localparam int DEPTH = SYNC + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loc = 1'b0, rem = 1'b0;
  logic [LANES-1:0] tx_p = '0, tx_n = '0, slc_p = '0, slc_n = '0;
  logic [LANES-1:0] line_p, line_n, rxo_p, rxo_n;
  logic out_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  e1_path_router #(.LANES(LANES), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .loc_lb_req(loc), .rem_lb_req(rem),
    .tx_p(tx_p), .tx_n(tx_n), .slc_p(slc_p), .slc_n(slc_n),
    .line_p(line_p), .line_n(line_n), .rxo_p(rxo_p), .rxo_n(rxo_n),
    .out_en(out_en)
  );

  // Reference model: history of control levels, oldest entry governs.
  logic [1:0] hist[$];
  logic [LANES-1:0] e_lp, e_ln, e_rp, e_rn;
  logic e_en;
  logic [1:0] e_mode;

  initial begin
    for (int i = 0; i < DEPTH; i++) hist.push_back(2'b00);
    e_lp = '0; e_ln = '0; e_rp = '0; e_rn = '0; e_en = 1'b1; e_mode = 2'b00;
  end

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i < DEPTH; i++) hist.push_back(2'b00);
      e_lp = '0; e_ln = '0; e_rp = '0; e_rn = '0; e_en = 1'b1; e_mode = 2'b00;
    end else begin
      e_mode = hist[0];
      case (e_mode)
        2'b00: begin e_lp = tx_p;  e_ln = tx_n;  e_rp = slc_p; e_rn = slc_n; e_en = 1; end
        2'b10: begin e_lp = tx_p;  e_ln = tx_n;  e_rp = tx_p;  e_rn = tx_n;  e_en = 1; end
        2'b01: begin e_lp = slc_p; e_ln = slc_n; e_rp = slc_p; e_rn = slc_n; e_en = 1; end
        default: begin e_lp = '0; e_ln = '0; e_rp = '0; e_rn = '0; e_en = 0; end
      endcase
      void'(hist.pop_front());
      hist.push_back({loc, rem});
    end
  end

  function automatic string tag_of(logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b10:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (line_p !== e_lp || line_n !== e_ln || rxo_p !== e_rp ||
        rxo_n !== e_rn || out_en !== e_en) begin
      fails++;
      $display("FAIL %s t=%0t actual line=%b/%b rx=%b/%b en=%b expected line=%b/%b rx=%b/%b en=%b",
               tag, $time, line_p, line_n, rxo_p, rxo_n, out_en,
               e_lp, e_ln, e_rp, e_rn, e_en);
    end
  endtask

  // Per-cycle comparison, R6/R7 covered by every cycle around mode changes.
  always @(negedge clk) begin
    if (cmp_on && !done) compare(tag_of(e_mode));
  end

  int seed = 32'h1d2c3b4a;

  task automatic rand_data();
    seed = seed * 1103515245 + 12345;
    tx_p  = seed[LANES+3:4];
    tx_n  = seed[LANES+9:10];
    seed = seed * 1103515245 + 12345;
    slc_p = seed[LANES+5:6];
    slc_n = seed[LANES+13:14];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rand_data();
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    // R1: reset state while reset is held
    repeat (3) @(negedge clk);
    tx_p = '1; slc_p = '1; loc = 1; rem = 1;
    @(negedge clk);
    compare("R1");
    loc = 0; rem = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    compare("R1");
    cmp_on = 1;
    // R2 normal
    run(30);
    // R3 local loop: slicer toggles randomly and must not show
    loc = 1; run(40);
    // R4 remote loop: transmit inputs toggle randomly and must not show
    loc = 0; rem = 1; run(40);
    // R5 test mode
    loc = 1; run(30);
    // R6: single-cycle glitch on control, then direct mode swaps
    loc = 0; rem = 0; run(10);
    @(negedge clk); loc = 1; rand_data();
    @(negedge clk); loc = 0; rand_data();
    run(10);
    @(negedge clk); rem = 1; loc = 1; rand_data();
    @(negedge clk); rem = 0; rand_data();
    run(10);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); {loc, rem} = k[1:0]; rand_data();
      run(k + 2);
    end
    // R7: one-rail-only patterns in every mode
    for (int m = 0; m < 4; m++) begin
      {loc, rem} = m[1:0];
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        tx_p = '1; tx_n = '0; slc_p = '0; slc_n = '1;
        @(negedge clk);
        tx_p = '0; tx_n = '1; slc_p = '1; slc_n = '0;
      end
    end
    run(8);
    finish_up();
  end

endmodule